// File: doc/BRIEF.md
# Mode-Switched Indexed Configuration Register Slave

This block is a small host I/O slave. It holds a slave control register, a bridge control register and a bank of byte-wide configuration registers. The host reaches the bank through an index port and a data port. The index port shares its offset with the bridge control register. A configuration-mode bit in the slave control register picks which of the two the shared offset decodes to. Host software sets the mode bit, writes the index, moves the data byte and then restores the mode bit.

Two bits of the slave control register drive the soft-reset and clock-stop outputs directly. The configuration bank is brought out as a flat vector for the functions it controls. A decoded serial-port base address is also provided, computed from the base-select field of the first serial-port configuration register.

Writes take effect on the rising clock edge that samples `wr_en`. Reads are combinational from `addr`. The asynchronous active-low reset is released to the logic through a two-flop synchronizer.

Top module: `hcfg_regs`

## Requirements
- R1: After reset every register reads 0. `soft_reset_o`, `clock_stop_o`, `brg_ctrl_o`, `cfg_bank_o` and `uart_en_o` are 0, and `uart_base_o` is 0x3F8.
- R2: Offset 0x0 is the slave control register. `wdata[2:0]` are stored: bit 0 is clock stop, bit 1 is soft reset, bit 2 is configuration mode. Read bits 15:3 are always 0.
- R3: `clock_stop_o` equals slave control bit 0 and `soft_reset_o` equals bit 1, in the cycle after the write.
- R4: With configuration mode clear, offset 0x2 is the bridge control register. Bits 3:0 are writable, bits 15:4 read 0, and the value appears on `brg_ctrl_o`. In this mode offset 0x3 reads 0 and writes to it have no effect.
- R5: With configuration mode set, offset 0x2 is the 8-bit index register: `wdata[7:0]` is stored and read bits 15:8 are 0. Writes there leave the bridge control register unchanged. Offset 0x3 reads and writes the configuration register selected by the index.
- R6: The defined indices and their writable bit masks are: 0x03→0x7F, 0x04→0x01, 0x07→0x3F, 0x08→0x01, 0x09→0xFF, 0x0A→0x03, 0x0F→0x01, 0x10→0x01, 0x11→0xFF. Bits outside a mask ignore writes and read 0. In `cfg_bank_o`, entry k of this list sits at bits [8k+7:8k].
- R7: With any index outside the defined list, offset 0x3 reads 0 and a write to it changes no register.
- R8: The status offset 0x1 reads 0 and ignores writes. Offsets 0x4 and above read 0.
- R9: `uart_base_o` decodes bits 6:5 of index 0x03 as 0→0x3F8, 1→0x2F8, 2→0x3E8, 3→0x2E8. `uart_en_o` is bit 0 of index 0x04.
- R10: The index register keeps its value while configuration mode is cleared and set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W (4) | Register offset |
| wdata | input | DATA_W (16) | Write data |
| rdata | output | DATA_W (16) | Combinational read data |
| soft_reset_o | output | 1 | Soft reset, slave control bit 1 |
| clock_stop_o | output | 1 | Clock stop, slave control bit 0 |
| brg_ctrl_o | output | BRG_W (4) | Bridge control writable bits |
| cfg_bank_o | output | 8*9 | All configuration registers, entry k at [8k+7:8k] |
| uart_base_o | output | 10 | Decoded serial-port base address |
| uart_en_o | output | 1 | Serial-port enable |

## Verification
The bench builds the block with its default parameters: a 4-bit offset, a 16-bit data path and a 4-bit bridge control field. With these values every offset from 0x0 to 0xF is reachable, so unmapped offsets are exercised. The upper byte of the data path lets the bench show that the index register and the byte-wide registers drop bits 15:8. The full 8-bit index space is also open, so the bench probes undefined indices that fall between defined ones.

// File: rtl/hcfg_pkg.sv
package hcfg_pkg;

  // Number of configuration entries in the indexed bank
  localparam int CFG_COUNT = 9;
  localparam int CFG_BITS  = CFG_COUNT * 8;

  // Entry positions used by the serial-port decode
  localparam int ENT_UART_A = 0;
  localparam int ENT_UART_B = 1;

  // Host offsets (the decode depends on these values)
  localparam int OFS_SCTL = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_SHR  = 2;
  localparam int OFS_DAT  = 3;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_SCTL,
    TGT_STAT,
    TGT_BRG,
    TGT_IDX,
    TGT_DAT
  } tgt_t;

  function automatic logic [7:0] cfg_index(input int k);
    case (k)
      0:       return 8'h03;
      1:       return 8'h04;
      2:       return 8'h07;
      3:       return 8'h08;
      4:       return 8'h09;
      5:       return 8'h0A;
      6:       return 8'h0F;
      7:       return 8'h10;
      default: return 8'h11;
    endcase
  endfunction

  function automatic logic [7:0] cfg_mask(input int k);
    case (k)
      0:       return 8'h7F;
      1:       return 8'h01;
      2:       return 8'h3F;
      3:       return 8'h01;
      4:       return 8'hFF;
      5:       return 8'h03;
      6:       return 8'h01;
      7:       return 8'h01;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [9:0] uart_base(input logic [1:0] sel);
    case (sel)
      2'd0:    return 10'h3F8;
      2'd1:    return 10'h2F8;
      2'd2:    return 10'h3E8;
      default: return 10'h2E8;
    endcase
  endfunction

endpackage

// File: rtl/hcfg_decode.sv
module hcfg_decode
  import hcfg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              cfg_mode,
  output tgt_t              tgt
);

  always_comb begin
    tgt = TGT_NONE;
    case (int'(addr))
      OFS_SCTL: tgt = TGT_SCTL;
      OFS_STAT: tgt = TGT_STAT;
      OFS_SHR:  tgt = cfg_mode ? TGT_IDX : TGT_BRG;
      OFS_DAT:  tgt = cfg_mode ? TGT_DAT : TGT_NONE;
      default:  tgt = TGT_NONE;
    endcase
  end

endmodule

// File: rtl/hcfg_slave_ctrl.sv
module hcfg_slave_ctrl #(
  parameter int CTRL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CTRL_W-1:0] wr_val,
  output logic [CTRL_W-1:0] ctrl_q
);

  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_stb) ctrl_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (wr_stb) ctrl_q <= ctrl_d;
  end

endmodule

// File: rtl/hcfg_bridge_ctrl.sv
module hcfg_bridge_ctrl #(
  parameter int BRG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [BRG_W-1:0] wr_val,
  output logic [BRG_W-1:0] brg_q
);

  logic [BRG_W-1:0] brg_d;

  always_comb begin
    brg_d = brg_q;
    if (wr_stb) brg_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      brg_q <= '0;
    else if (wr_stb) brg_q <= brg_d;
  end

endmodule

// File: rtl/hcfg_cfg_bank.sv
module hcfg_cfg_bank
  import hcfg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idx_wr,
  input  logic [7:0]          idx_val,
  input  logic                dat_wr,
  input  logic [7:0]          dat_val,
  output logic [7:0]          idx_q,
  output logic [7:0]          dat_rd,
  output logic                idx_hit,
  output logic [CFG_BITS-1:0] bank_o
);

  logic [7:0]           idx_d;
  logic [CFG_COUNT-1:0] sel_vec;
  logic [7:0]           ent_q [CFG_COUNT];

  always_comb begin
    idx_d = idx_q;
    if (idx_wr) idx_d = idx_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_wr) idx_q <= idx_d;
  end

  for (genvar g = 0; g < CFG_COUNT; g++) begin : g_ent
    localparam logic [7:0] ENT_IDX  = cfg_index(g);
    localparam logic [7:0] ENT_MASK = cfg_mask(g);
    logic       ent_en;
    logic [7:0] ent_d;

    assign sel_vec[g] = (idx_q == ENT_IDX);
    assign ent_en     = dat_wr & sel_vec[g];

    always_comb begin
      ent_d = ent_q[g];
      if (ent_en) ent_d = dat_val & ENT_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[g] <= '0;
      else if (ent_en) ent_q[g] <= ent_d;
    end

    assign bank_o[g*8 +: 8] = ent_q[g];
  end

  assign idx_hit = |sel_vec;

  always_comb begin
    dat_rd = '0;
    for (int k = 0; k < CFG_COUNT; k++) begin
      if (sel_vec[k]) dat_rd = dat_rd | ent_q[k];
    end
  end

endmodule

// File: rtl/hcfg_regs.sv
module hcfg_regs
  import hcfg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int BRG_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic                soft_reset_o,
  output logic                clock_stop_o,
  output logic [BRG_W-1:0]    brg_ctrl_o,
  output logic [CFG_BITS-1:0] cfg_bank_o,
  output logic [9:0]          uart_base_o,
  output logic                uart_en_o
);

  localparam int CTRL_W = 3;
  localparam int BIT_CLK_STOP = 0;
  localparam int BIT_SOFT_RST = 1;
  localparam int BIT_CFG_MODE = 2;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic [CTRL_W-1:0] sctl_q;
  logic              cfg_mode;
  tgt_t              tgt;
  logic [7:0]        idx_q;
  logic [7:0]        dat_rd;
  logic              idx_hit;

  assign cfg_mode = sctl_q[BIT_CFG_MODE];

  hcfg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (addr),
    .cfg_mode (cfg_mode),
    .tgt      (tgt)
  );

  hcfg_slave_ctrl #(.CTRL_W(CTRL_W)) u_sctl (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .wr_stb (wr_en && (tgt == TGT_SCTL)),
    .wr_val (wdata[CTRL_W-1:0]),
    .ctrl_q (sctl_q)
  );

  hcfg_bridge_ctrl #(.BRG_W(BRG_W)) u_brg (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .wr_stb (wr_en && (tgt == TGT_BRG)),
    .wr_val (wdata[BRG_W-1:0]),
    .brg_q  (brg_ctrl_o)
  );

  hcfg_cfg_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .idx_wr  (wr_en && (tgt == TGT_IDX)),
    .idx_val (wdata[7:0]),
    .dat_wr  (wr_en && (tgt == TGT_DAT)),
    .dat_val (wdata[7:0]),
    .idx_q   (idx_q),
    .dat_rd  (dat_rd),
    .idx_hit (idx_hit),
    .bank_o  (cfg_bank_o)
  );

  always_comb begin
    case (tgt)
      TGT_SCTL: rdata = DATA_W'(sctl_q);
      TGT_BRG:  rdata = DATA_W'(brg_ctrl_o);
      TGT_IDX:  rdata = DATA_W'(idx_q);
      TGT_DAT:  rdata = DATA_W'(dat_rd);
      default:  rdata = '0;
    endcase
  end

  assign clock_stop_o = sctl_q[BIT_CLK_STOP];
  assign soft_reset_o = sctl_q[BIT_SOFT_RST];
  assign uart_base_o  = uart_base(cfg_bank_o[ENT_UART_A*8+5 +: 2]);
  assign uart_en_o    = cfg_bank_o[ENT_UART_B*8];

endmodule

// File: rtl/hcfg_regs_chk.sv
module hcfg_regs_chk
  import hcfg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int BRG_W  = 4
) (
  input logic                clk,
  input logic                rst_q_n,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   wdata,
  input logic [DATA_W-1:0]   rdata,
  input logic                cfg_mode,
  input logic                idx_hit,
  input logic                soft_reset_o,
  input logic                clock_stop_o,
  input logic [BRG_W-1:0]    brg_ctrl_o,
  input logic [CFG_BITS-1:0] cfg_bank_o,
  input logic [9:0]          uart_base_o
);

  // R2
  sctl_reserved_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (int'(addr) == OFS_SCTL) |-> (rdata[DATA_W-1:3] == '0));

  // R3
  sctl_outputs_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && int'(addr) == OFS_SCTL) |=>
      (soft_reset_o == $past(wdata[1]) && clock_stop_o == $past(wdata[0])));

  // R4
  brg_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!cfg_mode && int'(addr) == OFS_SHR) |-> (rdata[DATA_W-1:BRG_W] == '0));

  // R5
  brg_hold_in_cfg_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && cfg_mode && int'(addr) == OFS_SHR) |=> $stable(brg_ctrl_o));

  // R7
  undef_idx_no_write_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && cfg_mode && int'(addr) == OFS_DAT && !idx_hit) |=> $stable(cfg_bank_o));

  // R8
  status_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (int'(addr) == OFS_STAT) |-> (rdata == '0));

  // R9
  uart_base_legal_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |-> (uart_base_o == 10'h3F8 || uart_base_o == 10'h2F8 ||
              uart_base_o == 10'h3E8 || uart_base_o == 10'h2E8));

endmodule

bind hcfg_regs hcfg_regs_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .BRG_W  (BRG_W)
) u_chk (
  .clk          (clk),
  .rst_q_n      (rst_q_n),
  .wr_en        (wr_en),
  .addr         (addr),
  .wdata        (wdata),
  .rdata        (rdata),
  .cfg_mode     (cfg_mode),
  .idx_hit      (idx_hit),
  .soft_reset_o (soft_reset_o),
  .clock_stop_o (clock_stop_o),
  .brg_ctrl_o   (brg_ctrl_o),
  .cfg_bank_o   (cfg_bank_o),
  .uart_base_o  (uart_base_o)
);

// File: tb/sim_hcfg_regs.sv
module sim_hcfg_regs;
  import hcfg_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 48;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                wr_en;
  logic [3:0]          addr;
  logic [15:0]         wdata;
  logic [15:0]         rdata;
  logic                soft_reset_o;
  logic                clock_stop_o;
  logic [3:0]          brg_ctrl_o;
  logic [CFG_BITS-1:0] cfg_bank_o;
  logic [9:0]          uart_base_o;
  logic                uart_en_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hcfg_regs u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .soft_reset_o (soft_reset_o),
    .clock_stop_o (clock_stop_o),
    .brg_ctrl_o   (brg_ctrl_o),
    .cfg_bank_o   (cfg_bank_o),
    .uart_base_o  (uart_base_o),
    .uart_en_o    (uart_en_o)
  );

  // {req[3:0], is_write, addr[3:0], wdata[15:0], expected[15:0]}
  localparam logic [40:0] VEC [NVEC] = '{
    {4'd4, 1'b1, 4'h2, 16'h00FF, 16'h0000},  // R4 bridge write
    {4'd4, 1'b0, 4'h2, 16'h0000, 16'h000F},
    {4'd4, 1'b0, 4'h3, 16'h0000, 16'h0000},
    {4'd4, 1'b1, 4'h3, 16'h1234, 16'h0000},
    {4'd4, 1'b0, 4'h2, 16'h0000, 16'h000F},
    {4'd2, 1'b1, 4'h0, 16'hFFFC, 16'h0000},  // R2 set mode only
    {4'd2, 1'b0, 4'h0, 16'h0000, 16'h0004},
    {4'd5, 1'b1, 4'h2, 16'h0003, 16'h0000},  // R5 index
    {4'd5, 1'b0, 4'h2, 16'h0000, 16'h0003},
    {4'd6, 1'b1, 4'h3, 16'h00FF, 16'h0000},  // R6 masks
    {4'd6, 1'b0, 4'h3, 16'h0000, 16'h007F},
    {4'd6, 1'b1, 4'h2, 16'h0004, 16'h0000},
    {4'd6, 1'b1, 4'h3, 16'hFFFF, 16'h0000},
    {4'd6, 1'b0, 4'h3, 16'h0000, 16'h0001},
    {4'd6, 1'b1, 4'h2, 16'h0007, 16'h0000},
    {4'd6, 1'b1, 4'h3, 16'hFFFF, 16'h0000},
    {4'd6, 1'b0, 4'h3, 16'h0000, 16'h003F},
    {4'd6, 1'b1, 4'h2, 16'h0008, 16'h0000},
    {4'd6, 1'b1, 4'h3, 16'hFFFF, 16'h0000},
    {4'd6, 1'b0, 4'h3, 16'h0000, 16'h0001},
    {4'd6, 1'b1, 4'h2, 16'h0009, 16'h0000},
    {4'd6, 1'b1, 4'h3, 16'hFFFF, 16'h0000},
    {4'd6, 1'b0, 4'h3, 16'h0000, 16'h00FF},
    {4'd6, 1'b1, 4'h2, 16'h000A, 16'h0000},
    {4'd6, 1'b1, 4'h3, 16'hFFFF, 16'h0000},
    {4'd6, 1'b0, 4'h3, 16'h0000, 16'h0003},
    {4'd6, 1'b1, 4'h2, 16'h000F, 16'h0000},
    {4'd6, 1'b1, 4'h3, 16'hFFFF, 16'h0000},
    {4'd6, 1'b0, 4'h3, 16'h0000, 16'h0001},
    {4'd6, 1'b1, 4'h2, 16'h0010, 16'h0000},
    {4'd6, 1'b1, 4'h3, 16'hFFFF, 16'h0000},
    {4'd6, 1'b0, 4'h3, 16'h0000, 16'h0001},
    {4'd6, 1'b1, 4'h2, 16'h0011, 16'h0000},
    {4'd6, 1'b1, 4'h3, 16'hFFFF, 16'h0000},
    {4'd6, 1'b0, 4'h3, 16'h0000, 16'h00FF},
    {4'd7, 1'b1, 4'h2, 16'h0005, 16'h0000},  // R7 undefined index
    {4'd7, 1'b1, 4'h3, 16'h00FF, 16'h0000},
    {4'd7, 1'b0, 4'h3, 16'h0000, 16'h0000},
    {4'd7, 1'b1, 4'h2, 16'h0011, 16'h0000},
    {4'd7, 1'b0, 4'h3, 16'h0000, 16'h00FF},
    {4'd5, 1'b1, 4'h2, 16'hFF00, 16'h0000},  // R5 upper byte dropped
    {4'd5, 1'b0, 4'h2, 16'h0000, 16'h0000},
    {4'd5, 1'b1, 4'h0, 16'h0000, 16'h0000},
    {4'd5, 1'b0, 4'h2, 16'h0000, 16'h000F},  // bridge untouched
    {4'd8, 1'b1, 4'h1, 16'hFFFF, 16'h0000},  // R8 status
    {4'd8, 1'b0, 4'h1, 16'h0000, 16'h0000},
    {4'd2, 1'b0, 4'h0, 16'h0000, 16'h0000},
    {4'd8, 1'b0, 4'h5, 16'h0000, 16'h0000}
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0]         v;
    logic [CFG_BITS-1:0] snap;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(4'h0, v);            check("R1 sctl", v, 16'h0);
    rd(4'h2, v);            check("R1 bridge", v, 16'h0);
    check("R1 soft_reset", soft_reset_o, 1'b0);
    check("R1 clock_stop", clock_stop_o, 1'b0);
    check("R1 bank", cfg_bank_o, '0);
    check("R1 uart_base", uart_base_o, 10'h3F8);
    check("R1 uart_en", uart_en_o, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][36]) wr(VEC[i][35:32], VEC[i][31:16]);
      else begin
        rd(VEC[i][35:32], v);
        check($sformatf("R%0d vec%0d", VEC[i][40:37], i), v, VEC[i][15:0]);
      end
    end

    // R3 reset and clock-stop outputs
    wr(4'h0, 16'h0002);
    check("R3 soft_reset set", soft_reset_o, 1'b1);
    check("R3 clock_stop clear", clock_stop_o, 1'b0);
    wr(4'h0, 16'h0001);
    check("R3 soft_reset clear", soft_reset_o, 1'b0);
    check("R3 clock_stop set", clock_stop_o, 1'b1);

    // R9 base decode and enable
    wr(4'h0, 16'h0004);
    check("R9 uart_en", uart_en_o, 1'b1);
    wr(4'h2, 16'h0003);
    wr(4'h3, 16'h0000); check("R9 base0", uart_base_o, 10'h3F8);
    wr(4'h3, 16'h0020); check("R9 base1", uart_base_o, 10'h2F8);
    wr(4'h3, 16'h0040); check("R9 base2", uart_base_o, 10'h3E8);
    wr(4'h3, 16'h0060); check("R9 base3", uart_base_o, 10'h2E8);

    // R7 undefined index leaves the bank untouched
    snap = cfg_bank_o;
    wr(4'h2, 16'h0012);
    wr(4'h3, 16'h00AA);
    check("R7 bank unchanged", cfg_bank_o, snap);

    // R10 index persists across mode toggles
    wr(4'h2, 16'h0009);
    wr(4'h0, 16'h0000);
    wr(4'h0, 16'h0004);
    rd(4'h2, v);
    check("R10 index kept", v, 16'h0009);

    // R1 reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 bank after reset", cfg_bank_o, '0);
    check("R1 bridge after reset", brg_ctrl_o, 4'h0);
    check("R1 soft_reset after reset", soft_reset_o, 1'b0);
    wr(4'h0, 16'h0004);
    rd(4'h2, v);
    check("R1 index after reset", v, 16'h0);

    finish_run();
  end

endmodule